// File: doc/BRIEF.md
# Packed-Code Equality Scan Pipeline

This block tests a whole word of packed, fixed-width unsigned codes against one query code in a single pass. The incoming data word is split into equal fields. Each field holds one code in its low bits and one spare bit above it, called the flag bit. The block does not compare each field on its own. It XORs the word with the query code copied into every field, adds a constant mask over the full word width, and XORs the sum with a mask that has only the flag bits set. After these three steps, each field's flag bit is 1 exactly when that field's code equals the query.

Words arrive on a valid/ready stream. The query code is captured together with each accepted word, so the query may change from one word to the next. The pipeline has five registered stages: capture, XOR, add, mask, and output. It accepts one word per clock cycle and produces one result word per input word. In the result word only the flag bits can be set. A second output gives the number of matching fields in that word. When the consumer holds off, the whole pipeline stalls and no word is lost or duplicated.

Top module: `eqScanTop`

## Requirements
- R1: Field f occupies bits [f*(CODE_W+1) +: CODE_W+1]. Its code is the low CODE_W bits and its flag bit is bit f*(CODE_W+1)+CODE_W. There are WORD_W/(CODE_W+1) fields, and any bits above the last field are unused. With the defaults (WORD_W=64, CODE_W=4) there are 12 fields, and bits 63:60 are unused.
- R2: In the result word, the flag bit of field f is 1 exactly when the code in field f equals `queryCode` as sampled in the same cycle the word was accepted.
- R3: Every bit of the result word other than a flag bit is 0, including the unused top bits.
- R4: The flag bits and the unused top bits of `inWord` have no effect on either output.
- R5: `outCount` equals the number of flag bits set in the result word it is presented with.
- R6: While `outReady` stays high, `inReady` stays high and one word is accepted every cycle. A word accepted at clock edge k is transferred out at edge k+5 at the earliest, so `outValid` rises after edge k+4.
- R7: While `outValid` is high and `outReady` is low, `inReady` is low and `outWord`/`outCount` hold their values. Every accepted word is delivered exactly once, in order.
- R8: After reset, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is valid |
| inReady | output | 1 | Block can accept a word this cycle |
| inWord | input | WORD_W | Packed code word |
| queryCode | input | CODE_W | Code to compare against, sampled with the word |
| outValid | output | 1 | Result word is valid |
| outReady | input | 1 | Consumer accepts the result this cycle |
| outWord | output | WORD_W | Result word; only flag bits may be set |
| outCount | output | CNT_W | Number of matching fields in `outWord` |

## Verification
The bench feeds words in which only the lowest or only the highest field matches. These words would expose a field misplaced or a carry leaking between fields. It also feeds words where all fields match, where none match, and where codes alternate. Query codes of all-zeros and all-ones probe the corners of the add step, where a zero XOR result must leave the flag bit clear and the widest XOR result must not carry into the next field. Words with the flag bits and unused bits set show that stray input bits are cleared. A random stream with ready held high measures latency and throughput, and a second random stream with random backpressure and a query that changes per word checks ordering, hold behaviour and the per-word query capture.

// File: rtl/eqScanPkg.sv
package eqScanPkg;
  localparam int NUM_STAGES = 5;

  typedef struct packed {
    logic                  advance;
    logic [NUM_STAGES-1:0] load;
  } stageCtl_t;
endpackage

// File: rtl/eqScanCtrl.sv
module eqScanCtrl
  import eqScanPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output logic      outValid,
  input  logic      outReady,
  output stageCtl_t ctl
);
  localparam int OCC_W = $clog2(NUM_STAGES + 1) + 1;

  logic [NUM_STAGES-1:0] stageValid;
  logic                  advance;

  assign advance  = !stageValid[NUM_STAGES-1] || outReady;
  assign inReady  = advance;
  assign outValid = stageValid[NUM_STAGES-1];

  always_comb begin
    ctl.advance = advance;
    ctl.load[0] = advance && inValid;
    for (int s = 1; s < NUM_STAGES; s++) begin
      ctl.load[s] = advance && stageValid[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= '0;
    end else if (advance) begin
      stageValid <= {stageValid[NUM_STAGES-2:0], inValid};
    end
  end

  // Occupancy tracking for the checks below
  logic [OCC_W-1:0] occupancy;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupancy <= '0;
    end else begin
      occupancy <= occupancy + OCC_W'(inValid && inReady) - OCC_W'(outValid && outReady);
    end
  end

  // R7
  occupancy_chk: assert property (@(posedge clk) disable iff (!rstN)
    occupancy == OCC_W'($countones(stageValid)));

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= OCC_W'(NUM_STAGES));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
endmodule

// File: rtl/eqScanDatapath.sv
module eqScanDatapath
  import eqScanPkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CODE_W = 4,
  localparam int FIELD_W    = CODE_W + 1,
  localparam int NUM_FIELDS = WORD_W / FIELD_W,
  localparam int CNT_W      = $clog2(NUM_FIELDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         ctl,
  input  logic [WORD_W-1:0] inWord,
  input  logic [CODE_W-1:0] queryCode,
  output logic [WORD_W-1:0] outWord,
  output logic [CNT_W-1:0]  outCount
);
  localparam int USED_W = NUM_FIELDS * FIELD_W;

  function automatic logic [WORD_W-1:0] buildMask(input logic flagsOnly);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      for (int b = 0; b < FIELD_W; b++) begin
        if ((b == CODE_W) == flagsOnly) m[f*FIELD_W + b] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FLAG_MASK = buildMask(1'b1);
  localparam logic [WORD_W-1:0] CODE_MASK = buildMask(1'b0);

  // Query code copied into every field, flag bits zero
  logic [WORD_W-1:0] queryWord;
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_rep
    assign queryWord[f*FIELD_W +: FIELD_W] = {1'b0, queryCode};
  end
  if (USED_W < WORD_W) begin : g_pad
    assign queryWord[WORD_W-1:USED_W] = '0;
  end

  logic [WORD_W-1:0] capWord, capQuery, xorWord, sumWord, flagWord, resWord;
  logic [CNT_W-1:0]  flagCount, resCount;

  always_comb begin
    flagCount = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      flagCount = flagCount + CNT_W'(flagWord[f*FIELD_W + CODE_W]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWord  <= '0;
      capQuery <= '0;
      xorWord  <= '0;
      sumWord  <= '0;
      flagWord <= '0;
      resWord  <= '0;
      resCount <= '0;
    end else begin
      if (ctl.load[0]) begin
        capWord  <= inWord & CODE_MASK;
        capQuery <= queryWord;
      end
      if (ctl.load[1]) xorWord  <= capWord ^ capQuery;
      if (ctl.load[2]) sumWord  <= xorWord + CODE_MASK;
      if (ctl.load[3]) flagWord <= (sumWord ^ FLAG_MASK) & FLAG_MASK;
      if (ctl.load[4]) begin
        resWord  <= flagWord;
        resCount <= flagCount;
      end
    end
  end

  assign outWord  = resWord;
  assign outCount = resCount;

  // R7
  stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.advance |=> $stable(outWord) && $stable(outCount));

  // R5
  count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outCount == CNT_W'($countones(outWord)));
endmodule

// File: rtl/eqScanTop.sv
module eqScanTop
  import eqScanPkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CODE_W = 4,
  localparam int CNT_W = $clog2(WORD_W / (CODE_W + 1) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  input  logic [CODE_W-1:0] queryCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outWord,
  output logic [CNT_W-1:0]  outCount
);
  stageCtl_t ctl;

  eqScanCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .ctl      (ctl)
  );

  eqScanDatapath #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inWord    (inWord),
    .queryCode (queryCode),
    .outWord   (outWord),
    .outCount  (outCount)
  );
endmodule

// File: tb/tb_eqScanTop.sv
`timescale 1ns/1ps
module tb_eqScanTop;
  localparam int WORD_W = 64;
  localparam int CODE_W = 4;
  localparam int FW     = CODE_W + 1;
  localparam int NF     = WORD_W / FW;
  localparam int CNT_W  = $clog2(NF + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [WORD_W-1:0] inWord = '0;
  logic [CODE_W-1:0] queryCode = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [WORD_W-1:0] outWord;
  logic [CNT_W-1:0] outCount;

  always #2 clk = ~clk;

  eqScanTop dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .queryCode(queryCode), .outValid(outValid),
    .outReady(outReady), .outWord(outWord), .outCount(outCount)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit stallMode = 0;
  bit done = 0;

  logic [WORD_W-1:0] expWordQ[$];
  logic [CNT_W-1:0]  expCntQ[$];
  int                expAccQ[$];
  bit                expLatQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (stallMode) outReady = ($urandom % 3) != 0;
    else outReady = 1'b1;
  end

  function automatic logic [WORD_W-1:0] refWord(logic [WORD_W-1:0] w, logic [CODE_W-1:0] q);
    logic [WORD_W-1:0] r = '0;
    for (int f = 0; f < NF; f++) begin
      if (w[f*FW +: CODE_W] == q) r[f*FW + CODE_W] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] refCount(logic [WORD_W-1:0] w, logic [CODE_W-1:0] q);
    logic [CNT_W-1:0] c = '0;
    for (int f = 0; f < NF; f++) begin
      if (w[f*FW +: CODE_W] == q) c = c + 1'b1;
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] fill(logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w = '0;
    for (int f = 0; f < NF; f++) w[f*FW +: CODE_W] = c;
    return w;
  endfunction

  // Driver: called at posedge+1, returns at posedge+1 after acceptance
  task automatic sendWord(logic [WORD_W-1:0] w, logic [CODE_W-1:0] q, bit latChk);
    inValid   = 1'b1;
    inWord    = w;
    queryCode = q;
    @(negedge clk);
    if (latChk) begin
      checks++;
      if (!inReady) begin
        fails++;
        $display("FAIL R6 inReady low with ready held high: got %0b expected 1", inReady);
      end
    end
    while (!inReady) @(negedge clk);
    expWordQ.push_back(refWord(w, q));
    expCntQ.push_back(refCount(w, q));
    expAccQ.push_back(cyc + 1);
    expLatQ.push_back(latChk);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && expWordQ.size() != 0; i++) @(posedge clk);
    #1;
  endtask

  // Monitor / scoreboard
  bit heldValid = 0;
  logic [WORD_W-1:0] heldWord;
  logic [CNT_W-1:0]  heldCnt;
  always @(negedge clk) begin
    if (rstN) begin
      if (heldValid) begin
        checks++;
        if (!outValid || outWord !== heldWord || outCount !== heldCnt) begin
          fails++;
          $display("FAIL R7 held output changed: got v=%0b %h/%0d expected v=1 %h/%0d",
                   outValid, outWord, outCount, heldWord, heldCnt);
        end
      end
      if (outValid && !outReady) begin
        checks++;
        if (inReady) begin
          fails++;
          $display("FAIL R7 inReady during stall: got %0b expected 0", inReady);
        end
      end
      heldValid = outValid && !outReady;
      heldWord  = outWord;
      heldCnt   = outCount;
      if (outValid && outReady) begin
        checks++;
        if (expWordQ.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected output: got %h expected none", outWord);
        end else begin
          logic [WORD_W-1:0] ew;
          logic [CNT_W-1:0] ec;
          int acc;
          bit lat;
          ew = expWordQ.pop_front();
          ec = expCntQ.pop_front();
          acc = expAccQ.pop_front();
          lat = expLatQ.pop_front();
          if (outWord !== ew) begin
            fails++;
            $display("FAIL R1/R2/R3/R4 result word: got %h expected %h", outWord, ew);
          end
          checks++;
          if (outCount !== ec) begin
            fails++;
            $display("FAIL R5 match count: got %0d expected %0d", outCount, ec);
          end
          if (lat) begin
            checks++;
            if ((cyc + 1) - acc != 5) begin
              fails++;
              $display("FAIL R6 latency: got %0d expected 5", (cyc + 1) - acc);
            end
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [WORD_W-1:0] w;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      fails++;
      $display("FAIL R8 reset state: got outValid=%0b inReady=%0b expected 0/1", outValid, inReady);
    end
    @(posedge clk); #1;

    // R1 lowest and highest field only
    w = fill(4'h3); w[0 +: CODE_W] = 4'h9;
    sendWord(w, 4'h9, 1'b1);
    w = fill(4'h3); w[(NF-1)*FW +: CODE_W] = 4'h9;
    sendWord(w, 4'h9, 1'b1);
    drain();
    // R2 all match, none match, alternating
    sendWord(fill(4'h7), 4'h7, 1'b1);
    sendWord(fill(4'h6), 4'h7, 1'b1);
    w = '0;
    for (int f = 0; f < NF; f++) w[f*FW +: CODE_W] = (f % 2) ? 4'hA : 4'h5;
    sendWord(w, 4'hA, 1'b1);
    sendWord(w, 4'h5, 1'b1);
    // Corners of the add step: zero codes, all-ones codes
    sendWord(fill(4'h0), 4'h0, 1'b1);
    sendWord(fill(4'hF), 4'hF, 1'b1);
    sendWord(fill(4'hF), 4'h0, 1'b1);
    sendWord(fill(4'h0), 4'hF, 1'b1);
    drain();
    // R4 dirty flag and unused bits
    sendWord({WORD_W{1'b1}}, 4'hF, 1'b1);
    sendWord(~fill(4'hF), 4'h0, 1'b1);
    sendWord(~fill(4'hF), 4'h1, 1'b1);
    drain();
    // R6 back-to-back random stream
    for (int i = 0; i < 40; i++) begin
      logic [CODE_W-1:0] q;
      q = CODE_W'($urandom % 4);
      w = {$urandom, $urandom};
      for (int f = 0; f < NF; f++) if ($urandom % 2) w[f*FW +: CODE_W] = q;
      sendWord(w, q, 1'b1);
    end
    drain();
    // R7 random backpressure, query changes per word
    stallMode = 1;
    @(posedge clk); #1;
    for (int i = 0; i < 80; i++) begin
      logic [CODE_W-1:0] q;
      q = CODE_W'($urandom);
      w = {$urandom, $urandom};
      for (int f = 0; f < NF; f++) if ($urandom % 3 == 0) w[f*FW +: CODE_W] = q;
      sendWord(w, q, 1'b0);
      if ($urandom % 4 == 0) begin
        @(posedge clk); #1;
      end
    end
    drain();
    stallMode = 0;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (expWordQ.size() != 0) begin
      fails++;
      $display("FAIL R7 words lost: got %0d pending expected 0", expWordQ.size());
    end
    finishRun();
  end
endmodule